// File: doc/BRIEF.md
# I2C-Controlled 16-Pin GPIO Expander Core

This block gives a host sixteen general-purpose pins, split into two 8-bit banks, that it reaches over an I2C target interface. SCL and SDA are sampled by the system clock. A byte-level target state machine decodes START, repeated START and STOP, and answers its own 7-bit address. The lower three bits of that address come from strap inputs, so several copies can share one bus. The first byte written after the address is a command that loads a register pointer. Each later data byte is written to, or read from, the register the pointer selects. After every such byte the pointer moves to the other bank of the same register pair.

Each bank has four registers: a direction register, an output latch, a polarity mask and a captured-input register. The direction register decides which pins are driven. Reading a bank's input register returns the live pins XORed with the polarity mask and also captures the pins into that bank's input register. An active-low interrupt output goes low whenever an input-direction pin differs from its captured value. Reading the bank again clears that bank's part of the interrupt.

Top module: `gpx_core`

## Requirements
- R1: After reset every pin is an input (`pin_oe` all 0), the output latches hold all ones (`pin_out` = 16'hFFFF), the polarity masks are 0, the captured inputs are all ones, `irq_n` is 1 and `sda_oe` is 0.
- R2: The target address is {4'b0100, `addr_sel`}. A matching address byte is acknowledged by pulling SDA low. A non-matching one is not acknowledged, and the bytes that follow it change no register.
- R3: The first byte written after the address is the command and sets the pointer. Commands 0/1 select the input registers, 2/3 the output latches, 4/5 the polarity masks and 6/7 the direction registers. An even command selects bank 0 (pins 7:0) and an odd command selects bank 1 (pins 15:8).
- R4: After each data byte, written or read, the pointer flips its bank bit and stays within the same register pair.
- R5: A direction bit of 1 makes its pin an input (`pin_oe` bit 0). A direction bit of 0 drives the pin with its output-latch bit (`pin_oe` bit 1). `pin_out` always shows the output latches.
- R6: A read of an input register returns the live pin values XORed with that bank's polarity mask.
- R7: The output, polarity and direction registers read back the value last written to them.
- R8: `irq_n` is 0 exactly when some input-direction pin, after synchronization, differs from its captured bit. A pin set to output never causes an interrupt.
- R9: Reading a bank's input register captures that bank's pins and clears that bank's part of the interrupt. It leaves the other bank's part unchanged.
- R10: Data bytes written while the pointer selects an input register are acknowledged and discarded, and they leave the captured values and the interrupt unchanged.
- R11: A STOP releases SDA and returns the target to idle, also in the middle of a byte, and a byte that is cut off is never committed. A repeated START begins a new address phase and keeps the pointer.
- R12: In a read, a NACK from the controller ends the transfer, and the target leaves SDA released until the next START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| addr_sel | input | 3 | Low three bits of the target address |
| pin_in | input | 16 | Pin levels as seen at the pads |
| pin_oe | output | 16 | Per-pin output enable |
| pin_out | output | 16 | Per-pin output value |
| irq_n | output | 1 | Active-low interrupt, open-drain style |

## Verification
The bench goes after pointer handling at pair boundaries. A design that moved the pointer to the next pair rather than the other bank would return the wrong register on the second byte of a read or write burst, or on the third. It flips polarity bits and toggles pins in one bank while reading only the other bank. A design that captured both banks together, or ignored direction when building the interrupt, would clear or raise `irq_n` at the wrong time. It also sends a foreign address, writes to the input registers and aborts a write in the middle of a byte with STOP. A target that acknowledged too freely, or committed a partly received byte, would change `pin_out` or `pin_oe` where they must hold.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

  typedef enum logic [2:0] {
    TS_IDLE,
    TS_ADDR,
    TS_AACK,
    TS_WR,
    TS_WACK,
    TS_RD,
    TS_RACK
  } tgt_state_t;

  // register kind held in the upper command bits
  typedef enum logic [1:0] {
    RK_INPUT  = 2'd0,
    RK_OUTPUT = 2'd1,
    RK_POL    = 2'd2,
    RK_DIR    = 2'd3
  } reg_kind_t;

  // full 7-bit target address from the fixed high part and the straps
  function automatic logic [6:0] own_address(input logic [3:0] base,
                                             input logic [2:0] sel);
    return {base, sel};
  endfunction

  // bits that raise the interrupt: input-direction pins that moved
  function automatic logic [7:0] bank_mismatch(input logic [7:0] live,
                                               input logic [7:0] captured,
                                               input logic [7:0] dir);
    return (live ^ captured) & dir;
  endfunction

  // value returned when an input register is read
  function automatic logic [7:0] input_view(input logic [7:0] live,
                                            input logic [7:0] pol);
    return live ^ pol;
  endfunction

endpackage

// File: rtl/gpx_line_sync.sv
module gpx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev, scl_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_now   = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_now & ~scl_prev;
  assign scl_fall  = ~scl_now & scl_prev;
  assign start_evt = scl_now & scl_prev & sda_prev & ~sda_s;
  assign stop_evt  = scl_now & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/gpx_i2c_target.sv
module gpx_i2c_target
  import gpx_pkg::*;
#(
  parameter logic [3:0] BASE_ADDR = 4'b0100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic [2:0] addr_sel,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       wr_evt,
  output logic       wr_first,
  output logic [7:0] wr_byte,
  output logic       rd_evt,
  output logic       addr_hit,
  output logic       addr_miss
);
  tgt_state_t state;
  logic [3:0] bitcnt;
  logic [7:0] shreg, txreg;
  logic       rw_q, first_q, nack_q;
  logic       bus_quiet, load_first, load_next;

  assign bus_quiet  = ~start_evt & ~stop_evt;
  assign load_first = bus_quiet & scl_fall & (state == TS_AACK) & rw_q;
  assign load_next  = bus_quiet & scl_fall & (state == TS_RACK) & ~nack_q;
  assign rd_evt     = load_first | load_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= TS_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      txreg     <= '0;
      rw_q      <= 1'b0;
      first_q   <= 1'b0;
      nack_q    <= 1'b0;
      sda_oe    <= 1'b0;
      wr_evt    <= 1'b0;
      wr_first  <= 1'b0;
      wr_byte   <= '0;
      addr_hit  <= 1'b0;
      addr_miss <= 1'b0;
    end else begin
      wr_evt    <= 1'b0;
      addr_hit  <= 1'b0;
      addr_miss <= 1'b0;
      if (start_evt) begin
        state   <= TS_ADDR;
        bitcnt  <= '0;
        first_q <= 1'b1;
        sda_oe  <= 1'b0;
      end else if (stop_evt) begin
        state  <= TS_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          TS_IDLE: ;
          TS_ADDR: begin
            if (scl_rise && bitcnt < 4'd8) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (shreg[7:1] == own_address(BASE_ADDR, addr_sel)) begin
                rw_q     <= shreg[0];
                sda_oe   <= 1'b1;
                state    <= TS_AACK;
                addr_hit <= 1'b1;
              end else begin
                state     <= TS_IDLE;
                addr_miss <= 1'b1;
              end
            end
          end
          TS_AACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw_q) begin
                txreg  <= rd_data;
                sda_oe <= ~rd_data[7];
                state  <= TS_RD;
              end else begin
                sda_oe <= 1'b0;
                state  <= TS_WR;
              end
            end
          end
          TS_WR: begin
            if (scl_rise && bitcnt < 4'd8) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              wr_evt   <= 1'b1;
              wr_first <= first_q;
              wr_byte  <= shreg;
              first_q  <= 1'b0;
              sda_oe   <= 1'b1;
              state    <= TS_WACK;
            end
          end
          TS_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              state  <= TS_WR;
            end
          end
          TS_RD: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe <= 1'b0;
                state  <= TS_RACK;
              end else begin
                bitcnt <= bitcnt + 4'd1;
                txreg  <= {txreg[6:0], 1'b0};
                sda_oe <= ~txreg[6];
              end
            end
          end
          TS_RACK: begin
            if (scl_rise) begin
              nack_q <= sda_s;
            end else if (scl_fall) begin
              if (nack_q) begin
                state <= TS_IDLE;
              end else begin
                bitcnt <= '0;
                txreg  <= rd_data;
                sda_oe <= ~rd_data[7];
                state  <= TS_RD;
              end
            end
          end
          default: state <= TS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
  import gpx_pkg::*;
#(
  parameter int NBANK = 2,
  parameter int BW    = 8,
  localparam int NPIN = NBANK * BW,
  localparam int SELW = $clog2(NBANK),
  localparam int CMDW = SELW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_evt,
  input  logic            wr_first,
  input  logic [7:0]      wr_byte,
  input  logic            rd_evt,
  input  logic [NPIN-1:0] pin_in,
  output logic [7:0]      rd_data,
  output logic [NPIN-1:0] pin_oe,
  output logic [NPIN-1:0] pin_out,
  output logic            irq_n
);
  logic [BW-1:0] out_q [NBANK];
  logic [BW-1:0] pol_q [NBANK];
  logic [BW-1:0] dir_q [NBANK];
  logic [BW-1:0] cap_q [NBANK];
  logic [CMDW-1:0] ptr_q;
  logic [NPIN-1:0] pin_s1, pin_s2;
  logic [NBANK-1:0] bank_irq;
  logic [1:0]       kind;
  logic [SELW-1:0]  bank;
  logic [SELW-1:0]  bank_next;

  assign kind      = ptr_q[CMDW-1:SELW];
  assign bank      = ptr_q[SELW-1:0];
  assign bank_next = bank + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_s1 <= '1;
      pin_s2 <= '1;
    end else begin
      pin_s1 <= pin_in;
      pin_s2 <= pin_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (wr_evt && wr_first) begin
      ptr_q <= wr_byte[CMDW-1:0];
    end else if (wr_evt || rd_evt) begin
      ptr_q <= {kind, bank_next};
    end
  end

  genvar gb;
  generate
    for (gb = 0; gb < NBANK; gb++) begin : g_bank
      logic sel_here;
      assign sel_here = (bank == gb[SELW-1:0]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_q[gb] <= '1;
          pol_q[gb] <= '0;
          dir_q[gb] <= '1;
          cap_q[gb] <= '1;
        end else begin
          if (wr_evt && !wr_first && sel_here) begin
            unique case (reg_kind_t'(kind))
              RK_OUTPUT: out_q[gb] <= wr_byte[BW-1:0];
              RK_POL:    pol_q[gb] <= wr_byte[BW-1:0];
              RK_DIR:    dir_q[gb] <= wr_byte[BW-1:0];
              default:   ;
            endcase
          end
          if (rd_evt && sel_here && reg_kind_t'(kind) == RK_INPUT) begin
            cap_q[gb] <= pin_s2[gb*BW +: BW];
          end
        end
      end

      assign bank_irq[gb]       = |bank_mismatch(pin_s2[gb*BW +: BW], cap_q[gb], dir_q[gb]);
      assign pin_oe[gb*BW +: BW]  = ~dir_q[gb];
      assign pin_out[gb*BW +: BW] = out_q[gb];
    end
  endgenerate

  always_comb begin
    unique case (reg_kind_t'(kind))
      RK_INPUT:  rd_data = input_view(pin_s2[bank*BW +: BW], pol_q[bank]);
      RK_OUTPUT: rd_data = out_q[bank];
      RK_POL:    rd_data = pol_q[bank];
      default:   rd_data = dir_q[bank];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n <= 1'b1;
    else        irq_n <= ~|bank_irq;
  end
endmodule

// File: rtl/gpx_core.sv
module gpx_core
  import gpx_pkg::*;
#(
  parameter logic [3:0] BASE_ADDR = 4'b0100,
  parameter int         NBANK     = 2,
  parameter int         BW        = 8,
  localparam int        NPIN      = NBANK * BW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe,
  input  logic [2:0]      addr_sel,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_oe,
  output logic [NPIN-1:0] pin_out,
  output logic            irq_n
);
  // named events, also watched by the checker
  logic       sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic       wr_evt, wr_first, rd_evt, addr_hit, addr_miss;
  logic [7:0] wr_byte, rd_data;

  gpx_line_sync #(.STAGES(2)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  gpx_i2c_target #(.BASE_ADDR(BASE_ADDR)) u_tgt (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .addr_sel  (addr_sel),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe),
    .wr_evt    (wr_evt),
    .wr_first  (wr_first),
    .wr_byte   (wr_byte),
    .rd_evt    (rd_evt),
    .addr_hit  (addr_hit),
    .addr_miss (addr_miss)
  );

  gpx_regs #(.NBANK(NBANK), .BW(BW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_evt   (wr_evt),
    .wr_first (wr_first),
    .wr_byte  (wr_byte),
    .rd_evt   (rd_evt),
    .pin_in   (pin_in),
    .rd_data  (rd_data),
    .pin_oe   (pin_oe),
    .pin_out  (pin_out),
    .irq_n    (irq_n)
  );
endmodule

// File: rtl/gpx_checker.sv
module gpx_checker #(
  parameter int NPIN = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_evt,
  input logic            stop_evt,
  input logic            wr_evt,
  input logic            rd_evt,
  input logic            addr_hit,
  input logic            addr_miss,
  input logic            sda_oe,
  input logic [NPIN-1:0] pin_oe,
  input logic [NPIN-1:0] pin_out,
  input logic            irq_n
);
  assert_reset_dflt_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0 && pin_out == '1 && irq_n && !sda_oe));

  assert_hit_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |-> sda_oe);

  assert_miss_nack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_miss |=> !sda_oe);

  assert_one_evt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_evt && rd_evt));

  assert_hold_pins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_evt |=> ($stable(pin_oe) && $stable(pin_out)));

  assert_out_noirq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe == '1) |=> irq_n);

  assert_stop_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  assert_start_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe);
endmodule

bind gpx_core gpx_checker #(.NPIN(NPIN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .wr_evt    (wr_evt),
  .rd_evt    (rd_evt),
  .addr_hit  (addr_hit),
  .addr_miss (addr_miss),
  .sda_oe    (sda_oe),
  .pin_oe    (pin_oe),
  .pin_out   (pin_out),
  .irq_n     (irq_n)
);

// File: tb/tb_gpx_core.sv
module tb_gpx_core;
  localparam int Q = 6;
  localparam logic [2:0] SEL = 3'b101;
  localparam logic [6:0] ME  = {4'b0100, SEL};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, irq_n, sda_line;
  logic [15:0] pins = 16'hFFFF;
  logic [15:0] pin_oe, pin_out;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  gpx_core dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(SEL), .pin_in(pins), .pin_oe(pin_oe), .pin_out(pin_out), .irq_n(irq_n)
  );

  int checks = 0, errors = 0;
  bit busy = 1'b1;
  int settle = 0;

  // reference model
  bit [7:0] m_out[2], m_pol[2], m_dir[2], m_cap[2];
  int m_ptr = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit m_irq_n();
    bit any = 0;
    for (int b = 0; b < 2; b++)
      if (((pins[b*8 +: 8] ^ m_cap[b]) & m_dir[b]) != 8'h00) any = 1;
    return !any;
  endfunction

  // per-clock comparison while the bus is quiet
  always @(negedge clk) begin
    if (rst_n && !busy) begin
      settle++;
      chk(pin_oe == ~{m_dir[1], m_dir[0]}, "R5", pin_oe, ~{m_dir[1], m_dir[0]});
      chk(pin_out == {m_out[1], m_out[0]}, "R5", pin_out, {m_out[1], m_out[0]});
      chk(!sda_oe, "R11", sda_oe, 0);
      if (settle > 4) chk(irq_n == m_irq_n(), "R8", irq_n, m_irq_n());
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pins(logic [15:0] v);
    pins = v;
    settle = 0;
    tick(8);
  endtask

  task automatic i2c_start();
    busy = 1'b1;
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q * 2);
    settle = 0;
    busy = 1'b0;
  endtask

  task automatic put_byte(logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    ack = !sda_line;
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic get_byte(bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(Q);
      b = {b[6:0], sda_line};
      scl_m = 1'b0;
    end
    tick(Q); sda_m = !give_ack; tick(Q); scl_m = 1'b1; tick(Q);
    scl_m = 1'b0; tick(Q); sda_m = 1'b1;
  endtask

  function automatic bit [7:0] m_read();
    int k = m_ptr >> 1, b = m_ptr & 1;
    bit [7:0] v;
    case (k)
      0: begin v = pins[b*8 +: 8] ^ m_pol[b]; m_cap[b] = pins[b*8 +: 8]; end
      1: v = m_out[b];
      2: v = m_pol[b];
      default: v = m_dir[b];
    endcase
    m_ptr = m_ptr ^ 1;
    return v;
  endfunction

  task automatic wr_regs(logic [7:0] cmd, logic [7:0] d[$], string req);
    bit ack;
    i2c_start();
    put_byte({ME, 1'b0}, ack); chk(ack, "R2", ack, 1);
    put_byte(cmd, ack); chk(ack, req, ack, 1);
    m_ptr = cmd & 7;
    foreach (d[i]) begin
      put_byte(d[i], ack); chk(ack, req, ack, 1);
      case (m_ptr >> 1)
        1: m_out[m_ptr & 1] = d[i];
        2: m_pol[m_ptr & 1] = d[i];
        3: m_dir[m_ptr & 1] = d[i];
        default: ;
      endcase
      m_ptr = m_ptr ^ 1;
    end
    i2c_stop();
  endtask

  // command write, repeated START, then n reads; last one NACKed
  task automatic rd_regs(logic [7:0] cmd, int n, string req);
    bit ack;
    logic [7:0] got, exp;
    i2c_start();
    put_byte({ME, 1'b0}, ack); chk(ack, "R2", ack, 1);
    put_byte(cmd, ack); chk(ack, "R3", ack, 1);
    m_ptr = cmd & 7;
    i2c_start();
    put_byte({ME, 1'b1}, ack); chk(ack, "R11", ack, 1);
    for (int i = 0; i < n; i++) begin
      exp = m_read();
      get_byte(i != n - 1, got);
      chk(got == exp, req, got, exp);
    end
    tick(Q);
    chk(!sda_oe, "R12", sda_oe, 0);
    i2c_stop();
  endtask

  initial begin
    for (int b = 0; b < 2; b++) begin
      m_out[b] = 8'hFF; m_pol[b] = 8'h00; m_dir[b] = 8'hFF; m_cap[b] = 8'hFF;
    end
    tick(4);
    rst_n = 1'b1;
    tick(2);
    // R1 reset state
    chk(pin_oe == 16'h0000, "R1", pin_oe, 16'h0000);
    chk(pin_out == 16'hFFFF, "R1", pin_out, 16'hFFFF);
    chk(irq_n == 1'b1, "R1", irq_n, 1);
    chk(!sda_oe, "R1", sda_oe, 0);
    busy = 1'b0;
    tick(10);
    rd_regs(8'd4, 2, "R1");

    // R3 R4 R5: direction then output latches, bank toggle in each burst
    wr_regs(8'd6, '{8'h0F, 8'hF0}, "R3");
    wr_regs(8'd2, '{8'hA5, 8'h3C, 8'h5A}, "R4");
    chk(pin_out == 16'h3C5A, "R4", pin_out, 16'h3C5A);
    chk(pin_oe == 16'h0FF0, "R5", pin_oe, 16'h0FF0);

    // R7 read back, starting from bank 1, wrapping within the pair
    rd_regs(8'd3, 3, "R7");
    wr_regs(8'd5, '{8'h81}, "R7");
    rd_regs(8'd4, 2, "R7");
    rd_regs(8'd7, 2, "R7");

    // R6 inputs with polarity
    set_pins(16'h5A3C);
    rd_regs(8'd0, 2, "R6");
    rd_regs(8'd1, 3, "R6");

    // R8: input pin in bank0 (bit 0 is input) raises irq
    set_pins(pins ^ 16'h0001);
    chk(irq_n == 1'b0, "R8", irq_n, 0);
    // R9: reading bank1 does not clear bank0's part
    rd_regs(8'd1, 1, "R9");
    chk(irq_n == 1'b0, "R9", irq_n, 0);
    // R10: writing input registers changes nothing
    wr_regs(8'd0, '{8'h00, 8'h00}, "R10");
    tick(3);
    chk(irq_n == 1'b0, "R10", irq_n, 0);
    rd_regs(8'd0, 1, "R9");
    tick(3);
    chk(irq_n == 1'b1, "R9", irq_n, 1);

    // R8: output-direction pins (bits 7:4, 11:8) never interrupt
    set_pins(pins ^ 16'h0FF0);
    chk(irq_n == 1'b1, "R8", irq_n, 1);
    // bank1 input bit 15 moves
    set_pins(pins ^ 16'h8000);
    chk(irq_n == 1'b0, "R8", irq_n, 0);
    rd_regs(8'd1, 1, "R9");
    tick(3);
    chk(irq_n == 1'b1, "R9", irq_n, 1);

    // R2: foreign address is not acknowledged, data ignored
    begin
      bit ack;
      i2c_start();
      put_byte({4'b0100, 3'b011, 1'b0}, ack);
      chk(!ack, "R2", ack, 0);
      put_byte(8'd2, ack);
      put_byte(8'h00, ack);
      i2c_stop();
      chk(pin_out == {m_out[1], m_out[0]}, "R2", pin_out, {m_out[1], m_out[0]});
    end

    // R11: STOP in the middle of a data byte commits nothing
    begin
      bit ack;
      i2c_start();
      put_byte({ME, 1'b0}, ack);
      put_byte(8'd6, ack);
      for (int i = 0; i < 4; i++) begin
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0; tick(Q);
      end
      i2c_stop();
      m_ptr = 6;
      chk(pin_oe == 16'h0FF0, "R11", pin_oe, 16'h0FF0);
    end
    rd_regs(8'd6, 2, "R11");

    tick(20);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule